// File: doc/BRIEF.md
# RAM-Based Longest-Prefix-Match Lookup Engine

This block resolves an IPv4 destination address to the longest stored route prefix using plain RAM rows and comparators instead of a ternary CAM. Routes are grouped into search devices, each bound to exactly one prefix length. Inside a device the storage is cut into equal tables. The table for a route is picked by the K lowest bits of the prefix within its length. Only the remaining upper bits are kept in the table's slots, since the table position already implies the index bits.

A search reads one table row from every device in the same cycle. It compares every valid slot of that row against the matching upper bits of the destination, and then keeps the hit from the device with the longest length. The result is a hit flag and an address that locates the entry. Routes are added and removed through a single update port. An insert into a full table is refused and reported. The defaults are kept small (4 devices of lengths 8, 16, 24 and 32, 16 tables per device, 8 slots per table). Larger arrays such as 256 tables of 128 slots are set through the parameters.

Top module: `lpm_engine`

## Requirements
- R1: An update is routed to the device whose length equals `upd_len_i`. An update whose length matches no device has no effect on any lookup.
- R2: For a device of length L, the table index is the K bits of the address at positions [32-L+K-1 : 32-L] (bit 31 is the first bit of the address). For a /16 route with K=4, these are bits [19:16]. The same bits of the destination select the table read in that device.
- R3: An entry matches a destination when both are in the same table and the top L-K address bits are equal. Address bits below position 32-L are ignored in both the stored route and the destination.
- R4: When several devices hit, the result comes from the device with the longest length. Device lengths increase with device index and each is at least K.
- R5: `hit_addr_o` is {device index (2 bits), table index (K bits), slot (3 bits)}, with the device index in the most significant bits. On a miss, `hit_o` is 0 and `hit_addr_o` is 0.
- R6: A response is presented (`rsp_valid_o`=1) exactly 2 cycles after the cycle in which `search_i` is high. A new search may be issued every cycle. `rsp_valid_o` is never high otherwise.
- R7: An insert (`upd_del_i`=0) places the route in the lowest-numbered free slot of its table. Inserting a route that is already stored has no effect.
- R8: An insert into a table with no free slot, for a route not already stored, leaves the contents unchanged. It raises `ovf_o` in the cycle after the insert and only then.
- R9: A delete (`upd_del_i`=1) frees the slot that holds the same route. Deleting a route that is not stored has no effect.
- R10: A search and an update in the same cycle: the search sees the contents from before the update.
- R11: After reset, no entry is valid and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| search_i | input | 1 | Search strobe |
| dst_i | input | 32 | Destination address to look up |
| upd_i | input | 1 | Update strobe |
| upd_del_i | input | 1 | 1 = delete, 0 = insert |
| upd_len_i | input | 6 | Prefix length of the update |
| upd_pfx_i | input | 32 | Route prefix of the update |
| rsp_valid_o | output | 1 | Response valid |
| hit_o | output | 1 | Some device matched |
| hit_addr_o | output | 9 | {device, table, slot} of the winning entry |
| ovf_o | output | 1 | Insert rejected, table full |

## Verification
The hardest state to reach from the ports is a table that is full. Reaching it needs eight distinct routes of one length that share their index bits but differ in their upper bits. The stimulus builds such a set on purpose, overflows it, deletes from the middle and refills the hole. A random phase then draws prefixes and destinations from a small pool of index and upper-bit values. This makes tables fill, duplicates recur and routes of different lengths nest, so longest-match choices and same-cycle search/update collisions occur often. A behavioural model in the bench predicts every output on every cycle.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 6;

  // upper (len-k) bits of the address kept, the rest cleared
  function automatic logic [ADDR_W-1:0] rem_mask(int len, int k);
    if (len <= k) return '0;
    return {ADDR_W{1'b1}} << (ADDR_W - len + k);
  endfunction

  // k index bits sitting just above bit position 32-len
  function automatic logic [ADDR_W-1:0] tbl_sel(logic [ADDR_W-1:0] p, int len, int k);
    logic [ADDR_W-1:0] s;
    s = p >> (ADDR_W - len);
    return s & ((32'd1 << k) - 32'd1);
  endfunction
endpackage

// File: rtl/lpm_first.sv
module lpm_first #(
  parameter int N = 8,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req_i,
  output logic         any_o,
  output logic [W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = W'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/lpm_device.sv
module lpm_device
  import lpm_pkg::*;
#(
  parameter int LEN      = 16,
  parameter int TBL_BITS = 4,
  parameter int SLOTS    = 8,
  localparam int N_TBL = 1 << TBL_BITS,
  localparam int RW    = ADDR_W - TBL_BITS,
  localparam int SW    = $clog2(SLOTS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                search_i,
  input  logic [ADDR_W-1:0]   dst_i,
  input  logic                upd_i,
  input  logic                upd_del_i,
  input  logic [ADDR_W-1:0]   upd_pfx_i,
  output logic                hit_o,
  output logic [TBL_BITS-1:0] tbl_o,
  output logic [SW-1:0]       slot_o,
  output logic                ovf_o
);
  function automatic logic [RW-1:0] key_of(logic [ADDR_W-1:0] p);
    logic [ADDR_W-1:0] m;
    m = p & rem_mask(LEN, TBL_BITS);
    return m[ADDR_W-1:TBL_BITS];
  endfunction

  function automatic logic [TBL_BITS-1:0] tbl_of(logic [ADDR_W-1:0] p);
    return p[ADDR_W-LEN +: TBL_BITS];
  endfunction

  logic [SLOTS-1:0] vld_q [N_TBL];
  logic [RW-1:0]    rem_q [N_TBL][SLOTS];

  // update path
  logic [TBL_BITS-1:0] u_tbl;
  logic [RW-1:0]       u_key;
  logic [SLOTS-1:0]    u_match, u_free;
  logic                u_has_free, u_ins, u_wr, u_del;
  logic [SW-1:0]       u_slot;

  assign u_tbl = tbl_of(upd_pfx_i);
  assign u_key = key_of(upd_pfx_i);

  always_comb begin
    for (int s = 0; s < SLOTS; s++) begin
      u_match[s] = vld_q[u_tbl][s] && (rem_q[u_tbl][s] == u_key);
    end
  end
  assign u_free = ~vld_q[u_tbl];

  lpm_first #(.N(SLOTS)) u_free_pick (
    .req_i (u_free),
    .any_o (u_has_free),
    .idx_o (u_slot)
  );

  assign u_ins = upd_i && !upd_del_i && !(|u_match);
  assign u_wr  = u_ins && u_has_free;
  assign u_del = upd_i && upd_del_i;
  assign ovf_o = u_ins && !u_has_free;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int t = 0; t < N_TBL; t++) vld_q[t] <= '0;
    end else if (u_wr) begin
      vld_q[u_tbl][u_slot] <= 1'b1;
    end else if (u_del) begin
      vld_q[u_tbl] <= vld_q[u_tbl] & ~u_match;
    end
  end

  always_ff @(posedge clk_i) begin
    if (u_wr) rem_q[u_tbl][u_slot] <= u_key;
  end

  // search stage 1: single row read
  logic [TBL_BITS-1:0] s_tbl, tbl_q;
  logic [SLOTS-1:0]    row_vld_q;
  logic [RW-1:0]       row_rem_q [SLOTS];
  logic [RW-1:0]       key_q;

  assign s_tbl = tbl_of(dst_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_vld_q <= '0;
      key_q     <= '0;
      tbl_q     <= '0;
    end else if (search_i) begin
      row_vld_q <= vld_q[s_tbl];
      key_q     <= key_of(dst_i);
      tbl_q     <= s_tbl;
    end
  end

  always_ff @(posedge clk_i) begin
    if (search_i) begin
      for (int s = 0; s < SLOTS; s++) row_rem_q[s] <= rem_q[s_tbl][s];
    end
  end

  // search stage 2: parallel compare
  logic [SLOTS-1:0] hv;
  always_comb begin
    for (int s = 0; s < SLOTS; s++) hv[s] = row_vld_q[s] && (row_rem_q[s] == key_q);
  end

  lpm_first #(.N(SLOTS)) u_hit_pick (
    .req_i (hv),
    .any_o (hit_o),
    .idx_o (slot_o)
  );

  assign tbl_o = tbl_q;
endmodule

// File: rtl/lpm_select.sv
module lpm_select #(
  parameter int N_DEV = 4,
  parameter int TW    = 4,
  parameter int SW    = 3,
  localparam int DW = $clog2(N_DEV),
  localparam int AW = DW + TW + SW
) (
  input  logic [N_DEV-1:0]    hit_i,
  input  logic [N_DEV*TW-1:0] tbl_i,
  input  logic [N_DEV*SW-1:0] slot_i,
  output logic                hit_o,
  output logic [AW-1:0]       addr_o
);
  // device order is length order, so the highest hitting index wins
  always_comb begin
    hit_o  = 1'b0;
    addr_o = '0;
    for (int d = 0; d < N_DEV; d++) begin
      if (hit_i[d]) begin
        hit_o  = 1'b1;
        addr_o = {DW'(d), tbl_i[d*TW +: TW], slot_i[d*SW +: SW]};
      end
    end
  end
endmodule

// File: rtl/lpm_engine.sv
module lpm_engine
  import lpm_pkg::*;
#(
  parameter int N_DEV    = 4,
  parameter int TBL_BITS = 4,
  parameter int SLOTS    = 8,
  parameter logic [N_DEV*LEN_W-1:0] DEV_LENS = {6'd32, 6'd24, 6'd16, 6'd8},
  localparam int DW = $clog2(N_DEV),
  localparam int SW = $clog2(SLOTS),
  localparam int AW = DW + TBL_BITS + SW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              search_i,
  input  logic [31:0]       dst_i,
  input  logic              upd_i,
  input  logic              upd_del_i,
  input  logic [5:0]        upd_len_i,
  input  logic [31:0]       upd_pfx_i,
  output logic              rsp_valid_o,
  output logic              hit_o,
  output logic [AW-1:0]     hit_addr_o,
  output logic              ovf_o
);
  logic [N_DEV-1:0]          dev_hit, dev_ovf;
  logic [N_DEV*TBL_BITS-1:0] dev_tbl;
  logic [N_DEV*SW-1:0]       dev_slot;

  for (genvar d = 0; d < N_DEV; d++) begin : g_dev
    localparam int L = int'(DEV_LENS[d*LEN_W +: LEN_W]);
    logic upd_here;
    assign upd_here = upd_i && (upd_len_i == LEN_W'(L));

    lpm_device #(
      .LEN      (L),
      .TBL_BITS (TBL_BITS),
      .SLOTS    (SLOTS)
    ) u_dev (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .search_i  (search_i),
      .dst_i     (dst_i),
      .upd_i     (upd_here),
      .upd_del_i (upd_del_i),
      .upd_pfx_i (upd_pfx_i),
      .hit_o     (dev_hit[d]),
      .tbl_o     (dev_tbl[d*TBL_BITS +: TBL_BITS]),
      .slot_o    (dev_slot[d*SW +: SW]),
      .ovf_o     (dev_ovf[d])
    );
  end

  logic          sel_hit;
  logic [AW-1:0] sel_addr;

  lpm_select #(
    .N_DEV (N_DEV),
    .TW    (TBL_BITS),
    .SW    (SW)
  ) u_sel (
    .hit_i  (dev_hit),
    .tbl_i  (dev_tbl),
    .slot_i (dev_slot),
    .hit_o  (sel_hit),
    .addr_o (sel_addr)
  );

  logic s1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q        <= 1'b0;
      rsp_valid_o <= 1'b0;
      hit_o       <= 1'b0;
      hit_addr_o  <= '0;
      ovf_o       <= 1'b0;
    end else begin
      s1_q        <= search_i;
      rsp_valid_o <= s1_q;
      hit_o       <= s1_q && sel_hit;
      hit_addr_o  <= (s1_q && sel_hit) ? sel_addr : '0;
      ovf_o       <= |dev_ovf;
    end
  end
endmodule

// File: rtl/lpm_engine_chk.sv
module lpm_engine_chk
  import lpm_pkg::*;
#(
  parameter int N_DEV    = 4,
  parameter int TBL_BITS = 4,
  parameter int SLOTS    = 8,
  parameter logic [N_DEV*LEN_W-1:0] DEV_LENS = {6'd32, 6'd24, 6'd16, 6'd8},
  localparam int DW = $clog2(N_DEV),
  localparam int SW = $clog2(SLOTS),
  localparam int AW = DW + TBL_BITS + SW
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          search_i,
  input logic [31:0]   dst_i,
  input logic          upd_i,
  input logic          upd_del_i,
  input logic          rsp_valid_o,
  input logic          hit_o,
  input logic [AW-1:0] hit_addr_o,
  input logic          ovf_o
);
  function automatic int dev_len(logic [DW-1:0] d);
    return int'(DEV_LENS[int'(d)*LEN_W +: LEN_W]);
  endfunction

  AST_RSP_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    search_i |-> ##2 rsp_valid_o); // R6
  AST_RSP_ORIGIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(search_i, 2)); // R6
  AST_MISS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> hit_addr_o == '0); // R5
  AST_HIT_IN_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> rsp_valid_o); // R5
  AST_OVF_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> $past(upd_i && !upd_del_i)); // R8
  AST_HIT_TABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> hit_addr_o[SW +: TBL_BITS] ==
      TBL_BITS'(tbl_sel($past(dst_i, 2), dev_len(hit_addr_o[AW-1 -: DW]), TBL_BITS))); // R2
endmodule

bind lpm_engine lpm_engine_chk #(
  .N_DEV    (N_DEV),
  .TBL_BITS (TBL_BITS),
  .SLOTS    (SLOTS),
  .DEV_LENS (DEV_LENS)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .search_i    (search_i),
  .dst_i       (dst_i),
  .upd_i       (upd_i),
  .upd_del_i   (upd_del_i),
  .rsp_valid_o (rsp_valid_o),
  .hit_o       (hit_o),
  .hit_addr_o  (hit_addr_o),
  .ovf_o       (ovf_o)
);

// File: tb/lpm_engine_test.sv
module lpm_engine_test;
  localparam int ND = 4;
  localparam int K  = 4;
  localparam int NT = 16;
  localparam int NS = 8;
  localparam int SW = 3;

  int lens [ND] = '{8, 16, 24, 32};

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        search_i = 1'b0;
  logic [31:0] dst_i = '0;
  logic        upd_i = 1'b0;
  logic        upd_del_i = 1'b0;
  logic [5:0]  upd_len_i = '0;
  logic [31:0] upd_pfx_i = '0;
  logic        rsp_valid_o, hit_o, ovf_o;
  logic [8:0]  hit_addr_o;

  lpm_engine uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .search_i(search_i), .dst_i(dst_i),
    .upd_i(upd_i), .upd_del_i(upd_del_i), .upd_len_i(upd_len_i),
    .upd_pfx_i(upd_pfx_i), .rsp_valid_o(rsp_valid_o), .hit_o(hit_o),
    .hit_addr_o(hit_addr_o), .ovf_o(ovf_o)
  );

  always #5 clk_i = ~clk_i;

  int    checks = 0;
  int    fails  = 0;
  string phase  = "R11 reset";

  // behavioural reference
  bit        mv [ND][NT][NS];
  bit [31:0] mr [ND][NT][NS];
  bit        pend_v, pend_h, cur_v, cur_h, exp_ovf;
  bit [8:0]  pend_a, cur_a;

  function automatic int tidx(bit [31:0] p, int L);
    return int'((p >> (32 - L)) & (NT - 1));
  endfunction
  function automatic bit [31:0] rkey(bit [31:0] p, int L);
    return p >> (32 - L + K);
  endfunction

  task automatic lookup(input bit [31:0] d, output bit h, output bit [8:0] a);
    int best;
    best = -1; h = 0; a = '0;
    for (int dv = 0; dv < ND; dv++) begin
      int t;
      bit found;
      t = tidx(d, lens[dv]);
      found = 0;
      for (int s = 0; s < NS; s++) begin
        if (!found && mv[dv][t][s] && mr[dv][t][s] == rkey(d, lens[dv])) begin
          found = 1;
          if (lens[dv] > best) begin
            best = lens[dv];
            h = 1;
            a = 9'((dv << (K + SW)) | (t << SW) | s);
          end
        end
      end
    end
  endtask

  task automatic apply(input bit del, input int len, input bit [31:0] p, output bit ov);
    ov = 0;
    for (int dv = 0; dv < ND; dv++) begin
      if (lens[dv] == len) begin
        int t, hole;
        bit dup;
        t = tidx(p, len); dup = 0; hole = -1;
        for (int s = 0; s < NS; s++) begin
          if (mv[dv][t][s] && mr[dv][t][s] == rkey(p, len)) begin
            dup = 1;
            if (del) mv[dv][t][s] = 0;
          end
        end
        if (!del && !dup) begin
          for (int s = NS - 1; s >= 0; s--) if (!mv[dv][t][s]) hole = s;
          if (hole < 0) ov = 1;
          else begin
            mv[dv][t][hole] = 1;
            mr[dv][t][hole] = rkey(p, len);
          end
        end
      end
    end
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int a = 0; a < ND; a++)
        for (int b = 0; b < NT; b++)
          for (int c = 0; c < NS; c++) mv[a][b][c] = 0;
      pend_v = 0; pend_h = 0; pend_a = '0;
      cur_v = 0; cur_h = 0; cur_a = '0; exp_ovf = 0;
    end else begin
      cur_v = pend_v; cur_h = pend_h; cur_a = pend_a;
      pend_v = search_i;
      if (search_i) lookup(dst_i, pend_h, pend_a);
      else begin pend_h = 0; pend_a = '0; end
      exp_ovf = 0;
      if (upd_i) apply(upd_del_i, int'(upd_len_i), upd_pfx_i, exp_ovf);
    end
  end

  always @(negedge clk_i) begin
    checks += 3;
    if (rsp_valid_o !== cur_v) begin
      fails++;
      $display("FAIL [%s] R6 rsp_valid act=%0b exp=%0b", phase, rsp_valid_o, cur_v);
    end
    if (hit_o !== cur_h || hit_addr_o !== cur_a) begin
      fails++;
      $display("FAIL [%s] R4/R5 hit/addr act=%0b/%h exp=%0b/%h", phase, hit_o, hit_addr_o, cur_h, cur_a);
    end
    if (ovf_o !== exp_ovf) begin
      fails++;
      $display("FAIL [%s] R8 ovf act=%0b exp=%0b", phase, ovf_o, exp_ovf);
    end
  end

  task automatic cyc(input bit s, input bit [31:0] d, input bit u, input bit del,
                     input int len, input bit [31:0] p);
    search_i = s; dst_i = d; upd_i = u; upd_del_i = del;
    upd_len_i = 6'(len); upd_pfx_i = p;
    @(negedge clk_i);
  endtask
  task automatic ins(input int len, input bit [31:0] p); cyc(0, 0, 1, 0, len, p); endtask
  task automatic del(input int len, input bit [31:0] p); cyc(0, 0, 1, 1, len, p); endtask
  task automatic srch(input bit [31:0] d); cyc(1, d, 0, 0, 0, 0); endtask
  task automatic idle(input int n); for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0); endtask

  function automatic bit [31:0] mk(int L, int r, int t);
    return (32'(r) << (32 - L + K)) | (32'(t) << (32 - L));
  endfunction

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;            // R11: outputs compared low during and after reset
    idle(2);

    phase = "R1 R2 R3 R4 nested routes";
    ins(8,  32'h0A00_0000);
    ins(16, 32'h0A01_0000);
    ins(24, 32'h0A01_0200);
    ins(32, 32'h0A01_0203);
    ins(12, 32'h0B00_0000);   // R1: no device of length 12
    srch(32'h0A01_0203); srch(32'h0A01_0209); srch(32'h0A01_0909);
    srch(32'h0A09_0909); srch(32'h0B00_0000); srch(32'h0A01_02FF);
    idle(3);

    phase = "R7 lowest slot and duplicate";
    ins(8, 32'h0A55_0000);    // same route, bits below /8 differ: duplicate
    ins(8, 32'h1A00_0000);
    srch(32'h1A12_3456); srch(32'h0AFF_FFFF);
    idle(3);

    phase = "R8 full table";
    for (int r = 2; r < 8; r++) ins(8, mk(8, r, 10));
    ins(8, mk(8, 8, 10));
    idle(1);
    srch(32'h8A01_0101); srch(32'h7A00_0000);
    idle(3);

    phase = "R9 delete and refill";
    del(8, mk(8, 3, 10));
    srch(32'h3A00_0000);
    del(8, mk(8, 9, 10));     // absent route
    ins(8, mk(8, 8, 10));
    srch(32'h8A00_0000); srch(32'h9A00_0000);
    idle(3);

    phase = "R10 same-cycle search and update";
    cyc(1, 32'hAB05_0000, 1, 0, 16, 32'hAB05_0000);
    srch(32'hAB05_0000);
    cyc(1, 32'hAB05_0000, 1, 1, 16, 32'hAB05_0000);
    srch(32'hAB05_0000);
    idle(3);

    phase = "R4 R5 R6 random mix";
    for (int i = 0; i < 4000; i++) begin
      bit s, u, dl;
      int dv, L;
      bit [31:0] d, p;
      s = ($urandom_range(0, 9) < 6);
      dv = $urandom_range(0, ND - 1);
      L = lens[dv];
      d = mk(L, $urandom_range(0, 3), $urandom_range(0, 3));
      if (L < 32) d = d | ($urandom() & (32'hFFFF_FFFF >> L));
      u = ($urandom_range(0, 9) < 4);
      dl = ($urandom_range(0, 9) < 3);
      dv = $urandom_range(0, ND - 1);
      L = ($urandom_range(0, 19) == 0) ? 12 : lens[dv];
      p = mk(L, $urandom_range(0, 3), $urandom_range(0, 3)) | ($urandom() & 32'h0000_000F);
      cyc(s, d, u, dl, L, p);
    end
    idle(4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule